// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block multiplies two operands and either returns the full product or folds it into a 64-bit running sum. The running sum is split into a low and a high 32-bit register, both visible at the ports. The first operand always comes from a register. The second comes either from a register or from an 8-bit immediate, which the unit sign-extends before use.

A two-bit operation code selects one of four operations:

| op | Operation |
|----|-----------|
| 0 | Unsigned 32×32 multiply |
| 1 | Word accumulate |
| 2 | Halfword accumulate |
| 3 | Byte accumulate |

The unsigned multiply writes its 64-bit product to a pair of result outputs and leaves the running sum alone. The three accumulate widths differ in how they interpret the operands:

- Word mode treats both operands as signed 32-bit values and adds the full signed 64-bit product.
- Halfword and byte modes take only the low 16 or 8 bits of each operand as signed values. They keep only the same number of low bits of the product and add those to the low register. Any carry from the low register flows into the high register.

An issuing pipeline drives one start pulse with the operands. It waits for the single-cycle done pulse before reading results or issuing again. A sticky overflow flag records any signed overflow of the high register. A synchronous clear zeroes both halves of the running sum and the flag.

Top module: `mac_unit`

## Requirements
- R1: After reset, both accumulator halves, both multiply result outputs, the overflow flag, busy and done are all zero.
- R2: When start is high at a clock edge with busy low, the operands and operation code are captured and busy is high from that edge. A start seen while busy is high has no effect on any output.
- R3: For a start accepted at edge N, the accumulator or multiply outputs take their new value at edge N+1. At edge N+2 done rises and busy falls, and done falls again at edge N+3.
- R4: When use_imm is 1, the second operand is the 8-bit immediate sign-extended to 32 bits; otherwise it is src_b.
- R5: Operation 1 (word accumulate) adds the signed 64-bit product of the two operands, each taken as signed 32-bit, to the 64-bit value {acc_hi, acc_lo}.
- R6: Operation 2 (halfword accumulate) multiplies bits [15:0] of each operand as signed 16-bit values and adds only bits [15:0] of the product, zero-extended, to acc_lo.
- R7: Operation 3 (byte accumulate) multiplies bits [7:0] of each operand as signed 8-bit values and adds only bits [7:0] of the product, zero-extended, to acc_lo.
- R8: An unsigned carry out of the acc_lo addition is added into acc_hi in every accumulate mode.
- R9: Operation 0 (unsigned multiply) places bits [31:0] of the unsigned 64-bit product on mul_lo and bits [63:32] on mul_hi, and leaves both accumulator halves unchanged. The multiply outputs hold their value through accumulate operations.
- R10: The overflow flag is set when the acc_hi addition (including the carry) overflows as a signed 32-bit value, and stays set through later operations until cleared.
- R11: A high clr at a clock edge zeroes both accumulator halves and the overflow flag, and takes priority over an accumulate update at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation code: 0 unsigned multiply, 1 word, 2 halfword, 3 byte accumulate |
| use_imm | input | 1 | Select the immediate as the second operand |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 8 | Immediate operand, sign-extended |
| clr | input | 1 | Synchronous clear of accumulator and overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mul_lo | output | 32 | Low half of the unsigned product |
| mul_hi | output | 32 | High half of the unsigned product |
| acc_lo | output | 32 | Low accumulator register |
| acc_hi | output | 32 | High accumulator register |
| ovf | output | 1 | Sticky signed overflow of the high register |

## Verification
The accumulate modes are driven with operands whose upper bits differ from their lower bits. A halfword or byte result that used the whole operand, or skipped the product mask, therefore gives a visibly different sum. One halfword case yields a product whose masked low half is zero, which separates masking from sign handling. Negative immediates and all-ones register operands tell signed word accumulation apart from the unsigned multiply and expose a missing sign extension. A running sum steered to a low half near its top checks carry propagation. A chain of large positive products crosses the signed limit of the high half to set the sticky flag, and later small operations confirm it persists until clear.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      OP_UMUL = 2'd0,
      OP_MACW = 2'd1,
      OP_MACH = 2'd2,
      OP_MACB = 2'd3
   } mac_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_WAIT = 2'd2
   } mac_state_e;

endpackage

// File: rtl/mac_operand_sel.sv
module mac_operand_sel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic [DATA_W-1:0] reg_a,
   input  logic [DATA_W-1:0] reg_b,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic              pick_imm,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   logic [DATA_W-1:0] imm_ext;

   initial begin
      assert (IMM_W >= 1 && IMM_W <= DATA_W)
         else $error("mac_operand_sel: IMM_W out of range");
   end

   generate
      if (IMM_W == DATA_W) begin : g_imm_full
         assign imm_ext = imm_val;
      end else begin : g_imm_sext
         assign imm_ext = {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
      end
   endgenerate

   assign opnd_a = reg_a;
   assign opnd_b = pick_imm ? imm_ext : reg_b;

endmodule

// File: rtl/mac_product.sv
module mac_product
   import mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  mac_op_e           mode,
   output logic [DATA_W-1:0] add_lo,
   output logic [DATA_W-1:0] add_hi,
   output logic [DATA_W-1:0] uprod_lo,
   output logic [DATA_W-1:0] uprod_hi
);

   localparam int HALF_W = DATA_W / 2;
   localparam int PROD_W = 2 * DATA_W;

   initial begin
      assert (DATA_W % 2 == 0) else $error("mac_product: DATA_W must be even");
      assert (BYTE_W >= 2 && BYTE_W < HALF_W)
         else $error("mac_product: BYTE_W must lie below half the word");
   end

   logic [PROD_W-1:0] wide_a_s, wide_b_s, wide_a_u, wide_b_u;
   logic [PROD_W-1:0] sprod, uprod;
   logic [DATA_W-1:0] lane_val [2];

   assign wide_a_s = {{DATA_W{opnd_a[DATA_W-1]}}, opnd_a};
   assign wide_b_s = {{DATA_W{opnd_b[DATA_W-1]}}, opnd_b};
   assign wide_a_u = {{DATA_W{1'b0}}, opnd_a};
   assign wide_b_u = {{DATA_W{1'b0}}, opnd_b};
   assign sprod    = wide_a_s * wide_b_s;
   assign uprod    = wide_a_u * wide_b_u;

   // Narrow lanes: lane 0 is the byte width, lane 1 the halfword width.
   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         localparam int LW = (g == 0) ? BYTE_W : HALF_W;
         logic [2*LW-1:0] la, lb, lp;
         assign la = {{LW{opnd_a[LW-1]}}, opnd_a[LW-1:0]};
         assign lb = {{LW{opnd_b[LW-1]}}, opnd_b[LW-1:0]};
         assign lp = la * lb;
         assign lane_val[g] = {{(DATA_W-LW){1'b0}}, lp[LW-1:0]};
      end
   endgenerate

   always_comb begin
      add_lo = '0;
      add_hi = '0;
      unique case (mode)
         OP_MACW: begin
            add_lo = sprod[DATA_W-1:0];
            add_hi = sprod[PROD_W-1:DATA_W];
         end
         OP_MACH: add_lo = lane_val[1];
         OP_MACB: add_lo = lane_val[0];
         default: ;
      endcase
   end

   assign uprod_lo = uprod[DATA_W-1:0];
   assign uprod_hi = uprod[PROD_W-1:DATA_W];

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              upd,
   input  logic [DATA_W-1:0] add_lo,
   input  logic [DATA_W-1:0] add_hi,
   output logic [DATA_W-1:0] acc_lo,
   output logic [DATA_W-1:0] acc_hi,
   output logic              ovf
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] sum_lo, sum_hi;
   logic              lo_carry, hi_ovf;

   assign sum_lo   = acc_lo + add_lo;
   assign lo_carry = (sum_lo < acc_lo) || (sum_lo < add_lo);
   assign sum_hi   = acc_hi + add_hi + {{(DATA_W-1){1'b0}}, lo_carry};
   assign hi_ovf   = (acc_hi[MSB] == add_hi[MSB]) && (sum_hi[MSB] != acc_hi[MSB]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_lo <= '0;
         acc_hi <= '0;
         ovf    <= 1'b0;
      end else if (clr) begin
         acc_lo <= '0;
         acc_hi <= '0;
         ovf    <= 1'b0;
      end else if (upd) begin
         acc_lo <= sum_lo;
         acc_hi <= sum_hi;
         if (hi_ovf) ovf <= 1'b1;
      end
   end

   // R11
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_lo == '0) && (acc_hi == '0) && !ovf);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);

   // R9
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd && !clr) |=> ($stable(acc_lo) && $stable(acc_hi)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              clr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] mul_lo,
   output logic [DATA_W-1:0] mul_hi,
   output logic [DATA_W-1:0] acc_lo,
   output logic [DATA_W-1:0] acc_hi,
   output logic              ovf
);

   mac_state_e        state;
   mac_op_e           op_q;
   logic [DATA_W-1:0] a_q, b_q;
   logic [IMM_W-1:0]  imm_q;
   logic              imm_sel_q;
   logic [DATA_W-1:0] opnd_a, opnd_b;
   logic [DATA_W-1:0] add_lo, add_hi, uprod_lo, uprod_hi;
   logic              exec, acc_upd;

   assign busy    = (state != ST_IDLE);
   assign exec    = (state == ST_EXEC);
   assign acc_upd = exec && (op_q != OP_UMUL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_q      <= OP_UMUL;
         a_q       <= '0;
         b_q       <= '0;
         imm_q     <= '0;
         imm_sel_q <= 1'b0;
         done      <= 1'b0;
         mul_lo    <= '0;
         mul_hi    <= '0;
      end else begin
         done <= (state == ST_WAIT);
         unique case (state)
            ST_IDLE: if (start) begin
               state     <= ST_EXEC;
               op_q      <= mac_op_e'(op);
               a_q       <= src_a;
               b_q       <= src_b;
               imm_q     <= imm;
               imm_sel_q <= use_imm;
            end
            ST_EXEC: begin
               state <= ST_WAIT;
               if (op_q == OP_UMUL) begin
                  mul_lo <= uprod_lo;
                  mul_hi <= uprod_hi;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   mac_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
      .reg_a(a_q), .reg_b(b_q), .imm_val(imm_q), .pick_imm(imm_sel_q),
      .opnd_a(opnd_a), .opnd_b(opnd_b)
   );

   mac_product #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_prod (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .mode(op_q),
      .add_lo(add_lo), .add_hi(add_hi),
      .uprod_lo(uprod_lo), .uprod_hi(uprod_hi)
   );

   mac_accum #(.DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .upd(acc_upd),
      .add_lo(add_lo), .add_hi(add_hi),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .ovf(ovf)
   );

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!busy && $past(busy)));

   // R9
   umul_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec && op_q == OP_UMUL && !clr) |=> ($stable(acc_lo) && $stable(acc_hi)));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        use_imm = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [7:0]  imm = '0;
   logic        clr = 1'b0;
   logic        busy, done, ovf;
   logic [31:0] mul_lo, mul_hi, acc_lo, acc_hi;

   int checks = 0;
   int errors = 0;

   logic [63:0] m_acc = '0;
   logic        m_ovf = 1'b0;
   logic [63:0] m_mul = '0;

   always #2 clk = ~clk;

   mac_unit dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_imm(use_imm),
      .src_a(src_a), .src_b(src_b), .imm(imm), .clr(clr),
      .busy(busy), .done(done), .mul_lo(mul_lo), .mul_hi(mul_hi),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .ovf(ovf)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] addend(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] sa, sb;
      logic [31:0] p;
      sa = {{32{a[31]}}, a};
      sb = {{32{b[31]}}, b};
      case (o)
         2'd1: return sa * sb;
         2'd2: begin p = {16'h0, a[15:0]} * {16'h0, b[15:0]}; return {48'h0, p[15:0]}; end
         2'd3: begin p = {24'h0, a[7:0]} * {24'h0, b[7:0]}; return {56'h0, p[7:0]}; end
         default: return 64'h0;
      endcase
   endfunction

   task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
      logic [63:0] ad, nx;
      if (o == 2'd0) begin
         m_mul = {32'h0, a} * {32'h0, b};
      end else begin
         ad = addend(o, a, b);
         nx = m_acc + ad;
         if ((m_acc[63] == ad[63]) && (nx[63] != m_acc[63])) m_ovf = 1'b1;
         m_acc = nx;
      end
   endtask

   task automatic check_state(input string req);
      chk(req, "acc_lo", {32'h0, acc_lo}, {32'h0, m_acc[31:0]});
      chk(req, "acc_hi", {32'h0, acc_hi}, {32'h0, m_acc[63:32]});
      chk(req, "ovf", {63'h0, ovf}, {63'h0, m_ovf});
      chk(req, "mul_lo", {32'h0, mul_lo}, {32'h0, m_mul[31:0]});
      chk(req, "mul_hi", {32'h0, mul_hi}, {32'h0, m_mul[63:32]});
   endtask

   // One operation with full timing checks (R2, R3).
   task automatic do_op(input string req, input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [7:0] iv, input logic ui);
      logic [31:0] bb;
      @(negedge clk);
      op = o; src_a = a; src_b = b; imm = iv; use_imm = ui; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R2", "busy after start", {63'h0, busy}, 64'h1);
      @(posedge clk);
      @(negedge clk);
      bb = ui ? {{24{iv[7]}}, iv} : b;
      model(o, a, bb);
      check_state(req);
      chk("R3", "done before finish", {63'h0, done}, 64'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R3", "done pulse", {63'h0, done}, 64'h1);
      chk("R3", "busy released", {63'h0, busy}, 64'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R3", "done falls", {63'h0, done}, 64'h0);
   endtask

   task automatic do_clear(input string req);
      @(negedge clk);
      clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
      m_acc = '0; m_ovf = 1'b0;
      check_state(req);
   endtask

   task automatic t_reset;
      // R1
      chk("R1", "busy", {63'h0, busy}, 64'h0);
      chk("R1", "done", {63'h0, done}, 64'h0);
      check_state("R1");
   endtask

   task automatic t_word;
      // R5 signed word product, negative result
      do_op("R5", 2'd1, 32'hFFFF_FFFD, 32'd7, 8'h00, 1'b0);
      chk("R5", "acc_hi sign fill", {32'h0, acc_hi}, 64'hFFFF_FFFF);
      // R4 negative immediate
      do_op("R4", 2'd1, 32'd1000, 32'h0000_0005, 8'hF0, 1'b1);
      chk("R4", "acc_lo", {32'h0, acc_lo}, {32'h0, 32'hFFFF_FFEB - 32'd16000});
   endtask

   task automatic t_half;
      do_clear("R11");
      // R6: -32768 * 2 -> low 16 bits are zero
      do_op("R6", 2'd2, 32'h0001_8000, 32'h0003_0002, 8'h00, 1'b0);
      chk("R6", "masked zero", {32'h0, acc_lo}, 64'h0);
      // R6: -1 * 0x2345 -> 0xDCBB
      do_op("R6", 2'd2, 32'hFFFF_FFFF, 32'h0001_2345, 8'h00, 1'b0);
      chk("R6", "masked value", {32'h0, acc_lo}, 64'h0000_DCBB);
   endtask

   task automatic t_byte;
      do_clear("R11");
      // R7: -1 * -128 = 128 -> 0x80
      do_op("R7", 2'd3, 32'h0000_01FF, 32'h0, 8'h80, 1'b1);
      chk("R7", "byte imm", {32'h0, acc_lo}, 64'h80);
      // R7: 0x7F * 0x7F = 0x3F01 -> 0x01
      do_op("R7", 2'd3, 32'h1234_567F, 32'hAB00_007F, 8'h00, 1'b0);
      chk("R7", "byte mask", {32'h0, acc_lo}, 64'h81);
   endtask

   task automatic t_carry;
      do_clear("R11");
      do_op("R8", 2'd1, 32'h0001_0000, 32'h0000_FFFF, 8'h00, 1'b0);
      do_op("R8", 2'd1, 32'h0001_0000, 32'h0000_0001, 8'h00, 1'b0);
      chk("R8", "carry into hi", {acc_hi, acc_lo}, 64'h0000_0001_0000_0000);
      // byte-mode carry: lo all ones plus 1
      do_op("R8", 2'd1, 32'hFFFF_FFFF, 32'h0000_0001, 8'h00, 1'b0);
      do_op("R8", 2'd3, 32'h0000_0001, 32'h0000_0001, 8'h00, 1'b0);
      chk("R8", "byte carry", {acc_hi, acc_lo}, 64'h0000_0001_0000_0000);
   endtask

   task automatic t_umul;
      // R9 all ones unsigned
      do_op("R9", 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, 1'b0);
      chk("R9", "umul product", {mul_hi, mul_lo}, 64'hFFFF_FFFE_0000_0001);
      chk("R9", "acc untouched", {acc_hi, acc_lo}, 64'h0000_0001_0000_0000);
      // R9 with sign-extended immediate treated unsigned (R4)
      do_op("R9", 2'd0, 32'd2, 32'h0, 8'hFF, 1'b1);
      chk("R4", "umul imm", {mul_hi, mul_lo}, 64'h0000_0001_FFFF_FFFE);
      // R9 multiply outputs hold through accumulate
      do_op("R9", 2'd2, 32'd3, 32'd3, 8'h00, 1'b0);
      chk("R9", "mul held", {mul_hi, mul_lo}, 64'h0000_0001_FFFF_FFFE);
   endtask

   task automatic t_ovf;
      do_clear("R11");
      do_op("R10", 2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'h00, 1'b0);
      do_op("R10", 2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'h00, 1'b0);
      chk("R10", "no ovf yet", {63'h0, ovf}, 64'h0);
      do_op("R10", 2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'h00, 1'b0);
      chk("R10", "ovf set", {63'h0, ovf}, 64'h1);
      do_op("R10", 2'd3, 32'd1, 32'd1, 8'h00, 1'b0);
      chk("R10", "ovf sticky", {63'h0, ovf}, 64'h1);
      do_clear("R11");
      chk("R11", "ovf cleared", {63'h0, ovf}, 64'h0);
   endtask

   task automatic t_clr_priority;
      do_op("R11", 2'd1, 32'd5, 32'd5, 8'h00, 1'b0);
      @(negedge clk);
      op = 2'd1; src_a = 32'd9; src_b = 32'd9; use_imm = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr = 1'b0;
      m_acc = '0; m_ovf = 1'b0;
      check_state("R11");
      repeat (2) @(posedge clk);
   endtask

   task automatic t_ignore;
      do_clear("R11");
      @(negedge clk);
      op = 2'd1; src_a = 32'd10; src_b = 32'd10; use_imm = 1'b0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      src_a = 32'd1000; src_b = 32'd1000;
      @(posedge clk);
      @(negedge clk);
      m_acc = 64'd100;
      check_state("R2");
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk("R2", "done", {63'h0, done}, 64'h1);
      @(posedge clk);
      @(negedge clk);
      chk("R2", "no second op busy", {63'h0, busy}, 64'h0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R2", "acc after ignored start", {acc_hi, acc_lo}, 64'd100);
      chk("R2", "no extra done", {63'h0, done}, 64'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word();
      t_half();
      t_byte();
      t_carry();
      t_umul();
      t_ovf();
      t_clr_priority();
      t_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule